// File: doc/BRIEF.md
# Indirect Register File Port

This block sits between an 8-bit processor I/O bus and the configuration registers of a video controller. The processor writes an index through a select port. It then moves bytes through a data port. A 64-entry index space sits behind the data port. The lower 32 entries are stored locally and shown to downstream logic as a flat vector. Entries 32 to 52 are passed on to an external command engine as a write strobe. Entries 53 and 54 read back a 16-bit word that comes from outside.

Each entry belongs to one access class: read/write, write-only, read-only or unused. Each locally stored entry also has a mask that is applied on writes. Two bits of the select byte control whether the index advances after data-port writes and after data-port reads. Each direction has its own bit, so a table can be streamed in or out, or one entry can be polled.

A control port turns on a hold mode. While this mode is set, data reads return all ones, data writes store zero and still advance the index, and select writes load zero. Entering the mode clears every local register and sends a one-cycle pulse that downstream logic uses to clear interrupt flags and command parameters.

Top module: `vdp_regfile_port`

## Requirements
- R1: The four address bits are decoded as follows: 3 is the data port, 4 is the select port and 7 is the control port. Reading any other address, or the select port, returns 0xFF, and writing any other address has no effect. After reset the select byte is 0xFF, every register is 0 and both control bits are 0.
- R2: After a data-port write, the index (select bits 5:0) advances by one modulo 64 with select bits 7:6 kept. When select bit 7 is set, the index stays put.
- R3: After a data-port read, the index advances by one modulo 64 only when select bit 6 is clear. When bit 6 is set, the select byte does not change.
- R4: Entries 0–5, 13, 14, 28 and 32–52 are write-only, and entries 53 and 54 are read-only. Entries 29–31 and 55–63 are unused, and every other entry below 29 is read/write. A read of a write-only or unused entry returns 0xFF. A write to a read-only or unused entry changes nothing and raises no strobe.
- R5: Writes to the local entries are ANDed with a mask: 0x87 for entry 9, 0x83 for 11, 0x0F for 12, 0xDF for 18, 0x07 for 19 and 23, 0xC1 for 22, 0x3F for 24, 0xCF for 25, and 0xFF for all others.
- R6: A read of entry 53 returns bits 7:0 of `ext_word`, and a read of entry 54 returns bits 15:8. In the cycle after a write to entry 32–52, `cmd_wr` is high for one cycle with `cmd_idx` and `cmd_data` holding the index and the byte.
- R7: In the cycle after a write to local entry i, bit i of `reg_wstb` is high for one cycle, and the new value appears in bits 8i+7:8i of `regs_flat`. At most one strobe bit is high at any time.
- R8: Bit 0 of a control-port write sets `clk_sel` and bit 1 sets hold mode. In hold mode, data reads return 0xFF and do not advance the index, data writes store 0 and advance it as in R2, and select writes load 0.
- R9: A control write that sets bit 1 while hold mode is off clears all local entries and pulses `mode_enter` for one cycle. Any other control write leaves the entries alone and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Low bus address bits |
| io_wdata | input | 8 | Bus write byte |
| io_wr | input | 1 | Write cycle, one clock |
| io_rd | input | 1 | Read cycle, one clock; ignored when io_wr is high |
| io_rdata | output | 8 | Combinational read byte for io_addr |
| ext_word | input | 16 | Value returned by entries 53/54 |
| cmd_wr | output | 1 | Command-parameter write strobe |
| cmd_idx | output | 6 | Index of the command parameter |
| cmd_data | output | 8 | Byte of the command parameter |
| regs_flat | output | 256 | Local entries 0–31, byte i at bits 8i+7:8i |
| reg_wstb | output | 32 | Per-entry write strobe |
| hold_mode | output | 1 | Hold mode active |
| clk_sel | output | 1 | Clock-select status bit |
| mode_enter | output | 1 | One-cycle pulse on entry to hold mode |

## Verification
Hold mode is the hardest case to reach from the ports. It reads back as all ones, so its effect on the index cannot be seen from a read. The stimulus enters the mode with registers already loaded, which shows that they are cleared. It then writes a select byte that must become zero, does one data write and one data read, and leaves the mode. Finally it writes once more. The strobe bit that this last write raises shows where the index ended up: it must reflect the advance from the write and no advance from the read.

// File: rtl/vdp_regfile_port.sv
module vdp_regfile_port #(
  parameter int DW = 8,
  parameter int IDXW = 6,
  parameter int NLOC = 32,
  parameter int CMD_LAST = 52,
  parameter logic [3:0] P_DATA = 4'h3,
  parameter logic [3:0] P_SEL = 4'h4,
  parameter logic [3:0] P_CTRL = 4'h7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          io_addr,
  input  logic [DW-1:0]       io_wdata,
  input  logic                io_wr,
  input  logic                io_rd,
  output logic [DW-1:0]       io_rdata,
  input  logic [2*DW-1:0]     ext_word,
  output logic                cmd_wr,
  output logic [IDXW-1:0]     cmd_idx,
  output logic [DW-1:0]       cmd_data,
  output logic [NLOC*DW-1:0]  regs_flat,
  output logic [NLOC-1:0]     reg_wstb,
  output logic                hold_mode,
  output logic                clk_sel,
  output logic                mode_enter
);
  localparam int LW = $clog2(NLOC);
  localparam int EXT_LO = CMD_LAST + 1;
  localparam int EXT_HI = CMD_LAST + 2;

  function automatic logic can_write(input logic [IDXW-1:0] i);
    return (i < 29) || (i >= NLOC && i <= CMD_LAST);
  endfunction

  function automatic logic can_read(input logic [IDXW-1:0] i);
    if (i == EXT_LO || i == EXT_HI) return 1'b1;
    if (i >= 29 || i <= 5) return 1'b0;
    return !(i == 13 || i == 14 || i == 28);
  endfunction

  function automatic logic [DW-1:0] wmask(input logic [IDXW-1:0] i);
    case (i)
      6'd9:         return 8'h87;
      6'd11:        return 8'h83;
      6'd12:        return 8'h0F;
      6'd18:        return 8'hDF;
      6'd19, 6'd23: return 8'h07;
      6'd22:        return 8'hC1;
      6'd24:        return 8'h3F;
      6'd25:        return 8'hCF;
      default:      return 8'hFF;
    endcase
  endfunction

  logic [DW-1:0] rf [NLOC];
  logic [DW-1:0] sel;
  wire [IDXW-1:0] idx = sel[IDXW-1:0];
  wire [IDXW-1:0] idx_nx = idx + 1'b1;
  wire [LW-1:0] lidx = idx[LW-1:0];
  wire dwr = io_wr && io_addr == P_DATA;
  wire drd = io_rd && !io_wr && io_addr == P_DATA;
  wire swr = io_wr && io_addr == P_SEL;
  wire cwr = io_wr && io_addr == P_CTRL;
  wire [DW-1:0] wdat = hold_mode ? '0 : io_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NLOC; k++) rf[k] <= '0;
      sel <= '1;
      hold_mode <= 1'b0;
      clk_sel <= 1'b0;
      mode_enter <= 1'b0;
      reg_wstb <= '0;
      cmd_wr <= 1'b0;
      cmd_idx <= '0;
      cmd_data <= '0;
    end else begin
      reg_wstb <= '0;
      cmd_wr <= 1'b0;
      mode_enter <= 1'b0;
      if (swr) sel <= wdat;
      if (dwr) begin
        if (can_write(idx)) begin
          if (idx < NLOC) begin
            rf[lidx] <= wdat & wmask(idx);
            reg_wstb[lidx] <= 1'b1;
          end else begin
            cmd_wr <= 1'b1;
            cmd_idx <= idx;
            cmd_data <= wdat;
          end
        end
        if (!sel[7]) sel <= {sel[7:6], idx_nx};
      end
      if (drd && !hold_mode && !sel[6]) sel <= {sel[7:6], idx_nx};
      if (cwr) begin
        clk_sel <= io_wdata[0];
        hold_mode <= io_wdata[1];
        if (io_wdata[1] && !hold_mode) begin
          for (int k = 0; k < NLOC; k++) rf[k] <= '0;
          mode_enter <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    io_rdata = '1;
    if (io_addr == P_DATA && !hold_mode && can_read(idx)) begin
      if (idx == EXT_LO) io_rdata = ext_word[DW-1:0];
      else if (idx == EXT_HI) io_rdata = ext_word[2*DW-1:DW];
      else if (idx < NLOC) io_rdata = rf[lidx];
    end
  end

  for (genvar g = 0; g < NLOC; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = rf[g];
  end
endmodule

// File: rtl/vdp_regfile_port_chk.sv
module vdp_regfile_port_chk #(
  parameter int DW = 8,
  parameter int NLOC = 32,
  parameter int CMD_LAST = 52,
  parameter logic [3:0] P_DATA = 4'h3,
  parameter logic [3:0] P_CTRL = 4'h7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         io_addr,
  input logic [DW-1:0]      io_wdata,
  input logic               io_wr,
  input logic               io_rd,
  input logic [DW-1:0]      io_rdata,
  input logic [DW-1:0]      sel,
  input logic               cmd_wr,
  input logic [5:0]         cmd_idx,
  input logic [NLOC*DW-1:0] regs_flat,
  input logic [NLOC-1:0]    reg_wstb,
  input logic               hold_mode,
  input logic               mode_enter
);
  wire dwr = io_wr && io_addr == P_DATA;
  wire drd = io_rd && !io_wr && io_addr == P_DATA;

  // R2
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && !sel[7] |=> sel[5:0] == 6'($past(sel[5:0]) + 6'd1) && sel[7:6] == $past(sel[7:6]));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drd && sel[6] |=> $stable(sel));
  // R4
  unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && sel[5:0] >= 6'd29 && sel[5:0] <= 6'd31 |=> reg_wstb == '0 && !cmd_wr);
  // R6
  cmd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> cmd_idx >= 6'(NLOC) && cmd_idx <= 6'(CMD_LAST));
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wstb));
  // R8
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_mode && io_addr == P_DATA |-> io_rdata == 8'hFF);
  // R9
  enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == P_CTRL && io_wdata[1] && !hold_mode |=> regs_flat == '0 && mode_enter);
endmodule

bind vdp_regfile_port vdp_regfile_port_chk #(
  .DW(DW), .NLOC(NLOC), .CMD_LAST(CMD_LAST), .P_DATA(P_DATA), .P_CTRL(P_CTRL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
  .io_rd(io_rd), .io_rdata(io_rdata), .sel(sel), .cmd_wr(cmd_wr), .cmd_idx(cmd_idx),
  .regs_flat(regs_flat), .reg_wstb(reg_wstb), .hold_mode(hold_mode), .mode_enter(mode_enter)
);

// File: tb/vdp_regfile_port_tb.sv
module vdp_regfile_port_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] io_addr = 0;
  logic [7:0] io_wdata = 0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_rdata;
  logic [15:0] ext_word = 16'hBEEF;
  logic cmd_wr, hold_mode, clk_sel, mode_enter;
  logic [5:0] cmd_idx;
  logic [7:0] cmd_data;
  logic [255:0] regs_flat;
  logic [31:0] reg_wstb;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic c_cmd, c_enter;
  logic [5:0] c_idx;
  logic [7:0] c_data;
  logic [31:0] c_wstb;

  always #10 clk = ~clk;

  vdp_regfile_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rd(io_rd), .io_rdata(io_rdata), .ext_word(ext_word), .cmd_wr(cmd_wr),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .regs_flat(regs_flat), .reg_wstb(reg_wstb),
    .hold_mode(hold_mode), .clk_sel(clk_sel), .mode_enter(mode_enter)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
    c_cmd = cmd_wr; c_idx = cmd_idx; c_data = cmd_data; c_wstb = reg_wstb; c_enter = mode_enter;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 0;
  endtask

  // {op, addr, data, expected}; op 0 = write, 1 = read and compare
  localparam int NV = 38;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 4'h4, 8'h09, 8'h00},  // R2 select entry 9
    {2'd0, 4'h3, 8'hFF, 8'h00},  // R5 entry 9 mask
    {2'd0, 4'h3, 8'hFF, 8'h00},  // R2 entry 10
    {2'd0, 4'h4, 8'h09, 8'h00},
    {2'd1, 4'h3, 8'h00, 8'h87},  // R5
    {2'd1, 4'h3, 8'h00, 8'hFF},  // R3 advanced to 10
    {2'd0, 4'h4, 8'h4B, 8'h00},  // R3 read inhibit
    {2'd0, 4'h3, 8'hFF, 8'h00},
    {2'd0, 4'h4, 8'h4B, 8'h00},
    {2'd1, 4'h3, 8'h00, 8'h83},  // R3
    {2'd1, 4'h3, 8'h00, 8'h83},  // R3 no advance
    {2'd0, 4'h4, 8'h00, 8'h00},
    {2'd0, 4'h3, 8'h55, 8'h00},
    {2'd0, 4'h4, 8'h00, 8'h00},
    {2'd1, 4'h3, 8'h00, 8'hFF},  // R4 write-only
    {2'd0, 4'h4, 8'h8F, 8'h00},  // R2 write inhibit
    {2'd0, 4'h3, 8'h01, 8'h00},
    {2'd0, 4'h3, 8'h02, 8'h00},
    {2'd0, 4'h4, 8'h0F, 8'h00},
    {2'd1, 4'h3, 8'h00, 8'h02},  // R2
    {2'd1, 4'h3, 8'h00, 8'h00},  // R2 entry 16 untouched
    {2'd0, 4'h4, 8'h35, 8'h00},
    {2'd1, 4'h3, 8'h00, 8'hEF},  // R6
    {2'd1, 4'h3, 8'h00, 8'hBE},  // R6
    {2'd0, 4'h9, 8'h00, 8'h00},  // R1 stray write
    {2'd1, 4'h4, 8'h00, 8'hFF},  // R1
    {2'd1, 4'h9, 8'h00, 8'hFF},  // R1
    {2'd0, 4'h4, 8'h12, 8'h00},
    {2'd0, 4'h3, 8'hFF, 8'h00}, {2'd0, 4'h3, 8'hFF, 8'h00},
    {2'd0, 4'h3, 8'hFF, 8'h00}, {2'd0, 4'h3, 8'hFF, 8'h00},
    {2'd0, 4'h3, 8'hFF, 8'h00}, {2'd0, 4'h3, 8'hFF, 8'h00},
    {2'd0, 4'h3, 8'hFF, 8'h00}, {2'd0, 4'h3, 8'hFF, 8'h00},
    {2'd0, 4'h4, 8'h12, 8'h00},
    {2'd1, 4'h3, 8'h00, 8'hDF}   // R5 entry 18
  };

  initial begin
    logic [7:0] d;
    logic [255:0] snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset regs", regs_flat, '0);
    chk("R1 reset ctrl", {hold_mode, clk_sel}, 0);
    io_addr = 4'h3; #1 chk("R1 reset read idx63", io_rdata, 8'hFF);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21:20] == 2'd0) wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][19:16], d);
        chk($sformatf("vector %0d", i), d, VEC[i][7:0]);
      end
    end
    // R5 remaining masks 19..25 (index at 19 after last read)
    rd(4'h3, d); chk("R5 entry 19", d, 8'h07);
    rd(4'h3, d); chk("R5 entry 20", d, 8'hFF);
    rd(4'h3, d); chk("R5 entry 21", d, 8'hFF);
    rd(4'h3, d); chk("R5 entry 22", d, 8'hC1);
    rd(4'h3, d); chk("R5 entry 23", d, 8'h07);
    rd(4'h3, d); chk("R5 entry 24", d, 8'h3F);
    rd(4'h3, d); chk("R5 entry 25", d, 8'hCF);

    // R2 wrap keeps bit 6
    wr(4'h4, 8'h7F); wr(4'h3, 8'h11); wr(4'h3, 8'h22);
    chk("R2 wrap to 0", regs_flat[7:0], 8'h22);
    chk("R7 strobe entry 0", c_wstb, 32'h1);

    // R6 command forwarding
    wr(4'h4, 8'h20); wr(4'h3, 8'h5A);
    chk("R6 cmd strobe", {c_cmd, c_idx, c_data}, {1'b1, 6'd32, 8'h5A});
    chk("R7 no local strobe on cmd", c_wstb, 0);
    wr(4'h4, 8'h35); wr(4'h3, 8'h99);
    chk("R4 read-only write", {c_cmd, c_wstb}, 0);
    snap = regs_flat;
    wr(4'h4, 8'h1E); wr(4'h3, 8'h44);
    chk("R4 unused write strobe", {c_cmd, c_wstb}, 0);
    chk("R4 unused write state", regs_flat, snap);

    // R9 control write without bit 1
    wr(4'h7, 8'h01);
    chk("R9 no clear", {c_enter, regs_flat}, {1'b0, snap});
    chk("R8 clk_sel", clk_sel, 1'b1);
    // R9 enter hold
    wr(4'h7, 8'h03);
    chk("R9 enter pulse", c_enter, 1'b1);
    chk("R9 cleared", regs_flat, '0);
    chk("R8 hold on", hold_mode, 1'b1);
    wr(4'h4, 8'h15); wr(4'h3, 8'h77);
    chk("R8 write stores zero", {c_wstb, regs_flat[7:0]}, {32'h1, 8'h00});
    rd(4'h3, d); chk("R8 read FF", d, 8'hFF);
    wr(4'h7, 8'h00);
    chk("R9 leave no pulse", c_enter, 1'b0);
    wr(4'h3, 8'h33);
    chk("R8 index after hold", c_wstb, 32'h2);
    chk("R8 value after hold", regs_flat[15:8], 8'h33);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule